// File: doc/BRIEF.md
# Serial Command Receiver with Daisy-Chain Output

This block takes 16-bit command frames from a three-wire serial link: a data line, a serial clock and a load strobe. In one build option the load strobe also acts as an active-low chip select. The serial clock, data and load inputs are all oversampled in the system clock domain. Each received bit travels through a 16-bit shift register and leaves on a serial output half a serial period after it is pushed out of the register. The output changes on falling serial clock edges, so identical receivers can be chained output to input and share one load line.

A rising load edge commits the most recent 16 bits. The frame's address field selects one of eight digit registers or one of five control registers, and its data field is written there. Address zero and the unassigned addresses change nothing, so a no-op frame lets a chained receiver be skipped. All register contents are exposed in parallel for a downstream display scan engine. Two decoded flags are also provided: standby (shutdown) and the all-on test mode.

A small controller tracks each frame with three states. ST_IDLE means no bit has arrived since the last commit. ST_SHIFT means bits are arriving. ST_COMMIT lasts one cycle and writes the captured command. The transitions are as follows. ST_IDLE goes to ST_SHIFT on an accepted rising serial clock edge. ST_IDLE and ST_SHIFT both go to ST_COMMIT on a rising load edge. ST_COMMIT goes to ST_SHIFT if a serial clock edge is accepted in the same cycle, and to ST_IDLE otherwise.

Top module: `disp_cmd_rx`

## Requirements
- R1: A frame is 16 bits sent most significant bit first. Frame bits 11..8 are the register address, bits 7..0 are the data, and bits 15..12 have no effect.
- R2: A bit taken in on a rising serial clock edge appears on `ser_dout_o` after the falling serial edge that ends the 17th serial period (16.5 periods later). `ser_dout_o` changes only after falling serial clock edges.
- R3: A rising edge of `ser_load_i` commits the last 16 bits shifted in. This includes a load edge that arrives together with the 16th rising serial edge. When more than 16 bits are sent, only the last 16 count. Register outputs reflect a commit within four system clock cycles of the load edge at the pin.
- R4: The address map is as follows. Addresses 1..8 write digit registers 0..7, and digit k occupies bits 8k+7..8k of `digit_bus_o`. Address 9 writes `decode_sel_o`, A writes `level_o`, B writes `scan_lim_o`, C writes `power_o` and F writes `test_reg_o`.
- R5: Frames with address 0, D or E change no register and no register output.
- R6: After reset, every control register and every digit register reads zero. `shutdown_o` is 1, `test_mode_o` is 0 and `ser_dout_o` is 0.
- R7: `shutdown_o` is the inverse of bit 0 of the power register, and `test_mode_o` equals bit 0 of the test register. Writes are accepted while in shutdown and are kept across entering and leaving it.
- R8: With `CS_MODE` = 1, serial clock edges shift data in or out only while `ser_load_i` is low. With `CS_MODE` = 0, every serial clock edge shifts, whatever the level of `ser_load_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock |
| ser_din_i | input | 1 | Serial data in |
| ser_load_i | input | 1 | Load strobe; active-low chip select when CS_MODE = 1 |
| ser_dout_o | output | 1 | Serial data out for chaining |
| digit_bus_o | output | DIGITS*8 | All digit registers, digit k at bits 8k+7..8k |
| decode_sel_o | output | 8 | Per-digit decode select register |
| level_o | output | 8 | Brightness level register |
| scan_lim_o | output | 8 | Scan limit register |
| power_o | output | 8 | Power register (bit 0: 1 = normal operation) |
| test_reg_o | output | 8 | Display test register |
| shutdown_o | output | 1 | 1 while in shutdown |
| test_mode_o | output | 1 | 1 while the all-on test mode is selected |

## Verification
Two receivers, one per `CS_MODE` value, share one stimulus and are compared every cycle against a behavioural model. The stimulus covers several cases:
- Plain frames with junk in the ignored nibble, which separate the address and data fields from the don't-care bits.
- A load edge that coincides with the 16th clock edge, which exposes a capture taken one bit early.
- A 17-bit burst, which shows that only the latest 16 bits count.
- Serial clocks sent while load is high, which separate the two interface modes.
- A 32-bit burst, whose second half reproduces the first on the serial output. This pins the 16.5-period delay against off-by-one shifts.

// File: rtl/disp_rx_pkg.sv
package disp_rx_pkg;

    localparam int FRAME_W  = 16;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 8;
    localparam int ADDR_LSB = DATA_W;
    localparam int CMD_W    = ADDR_W + DATA_W;

    localparam logic [ADDR_W-1:0] A_NOP    = 4'h0;
    localparam logic [ADDR_W-1:0] A_DIG0   = 4'h1;
    localparam logic [ADDR_W-1:0] A_DECODE = 4'h9;
    localparam logic [ADDR_W-1:0] A_LEVEL  = 4'hA;
    localparam logic [ADDR_W-1:0] A_SCAN   = 4'hB;
    localparam logic [ADDR_W-1:0] A_POWER  = 4'hC;
    localparam logic [ADDR_W-1:0] A_TEST   = 4'hF;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_i[i]};
            end
        end

        assign level_o[i] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/rx_shifter.sv
module rx_shifter
    import disp_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en_i,
    input  logic out_en_i,
    input  logic din_i,
    output cmd_t cur_o,
    output cmd_t next_o,
    output logic dout_o
);

    logic [FRAME_W-1:0] word_q;
    logic [FRAME_W-1:0] word_d;
    logic               spill_q;
    logic               dout_q;

    // Next content of the shift register once the pending bit enters
    assign word_d = {word_q[FRAME_W-2:0], din_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q  <= '0;
            spill_q <= 1'b0;
        end else if (shift_en_i) begin
            word_q  <= word_d;
            spill_q <= word_q[FRAME_W-1];
        end
    end

    // Bit pushed out of the register is retimed to the falling serial edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= 1'b0;
        end else if (out_en_i) begin
            dout_q <= spill_q;
        end
    end

    assign cur_o  = word_q[CMD_W-1:0];
    assign next_o = word_d[CMD_W-1:0];
    assign dout_o = dout_q;

endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
    import disp_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      shift_en_i,
    input  logic      load_rise_i,
    input  cmd_t      frame_cmd_i,
    output rx_state_e state_o,
    output logic      wr_en_o,
    output cmd_t      cmd_o
);

    rx_state_e state_q;
    rx_state_e state_d;
    cmd_t      cmd_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Command held from the load edge until the commit cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (load_rise_i) begin
            cmd_q <= frame_cmd_i;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_rise_i) begin
                    state_d = ST_COMMIT;
                end else if (shift_en_i) begin
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (load_rise_i) begin
                    state_d = ST_COMMIT;
                end
            end
            ST_COMMIT: begin
                state_d = shift_en_i ? ST_SHIFT : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        wr_en_o = (state_q == ST_COMMIT);
        cmd_o   = cmd_q;
        state_o = state_q;
    end

endmodule

// File: rtl/rx_regfile.sv
module rx_regfile
    import disp_rx_pkg::*;
#(
    parameter int DIGITS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  cmd_t                     cmd_i,
    output logic [DIGITS*DATA_W-1:0] digits_o,
    output logic [DATA_W-1:0]        decode_o,
    output logic [DATA_W-1:0]        level_o,
    output logic [DATA_W-1:0]        scan_o,
    output logic [DATA_W-1:0]        power_o,
    output logic [DATA_W-1:0]        test_o
);

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(int'(A_DIG0) + g);
        logic [DATA_W-1:0] dig_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dig_q <= '0;
            end else if (wr_en_i && (cmd_i.addr == SLOT)) begin
                dig_q <= cmd_i.data;
            end
        end

        assign digits_o[g*DATA_W +: DATA_W] = dig_q;
    end

    logic [DATA_W-1:0] decode_q, level_q, scan_q, power_q, test_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            decode_q <= '0;
            level_q  <= '0;
            scan_q   <= '0;
            power_q  <= '0;
            test_q   <= '0;
        end else if (wr_en_i) begin
            case (cmd_i.addr)
                A_DECODE: decode_q <= cmd_i.data;
                A_LEVEL:  level_q  <= cmd_i.data;
                A_SCAN:   scan_q   <= cmd_i.data;
                A_POWER:  power_q  <= cmd_i.data;
                A_TEST:   test_q   <= cmd_i.data;
                default:  ;
            endcase
        end
    end

    assign decode_o = decode_q;
    assign level_o  = level_q;
    assign scan_o   = scan_q;
    assign power_o  = power_q;
    assign test_o   = test_q;

endmodule

// File: rtl/disp_cmd_rx.sv
module disp_cmd_rx
    import disp_rx_pkg::*;
#(
    parameter int DIGITS      = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit CS_MODE     = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_clk_i,
    input  logic                     ser_din_i,
    input  logic                     ser_load_i,
    output logic                     ser_dout_o,
    output logic [DIGITS*DATA_W-1:0] digit_bus_o,
    output logic [DATA_W-1:0]        decode_sel_o,
    output logic [DATA_W-1:0]        level_o,
    output logic [DATA_W-1:0]        scan_lim_o,
    output logic [DATA_W-1:0]        power_o,
    output logic [DATA_W-1:0]        test_reg_o,
    output logic                     shutdown_o,
    output logic                     test_mode_o
);

    localparam int IN_CLK = 0;
    localparam int IN_DIN = 1;
    localparam int IN_LD  = 2;
    localparam int IN_W   = 3;

    logic [IN_W-1:0] lvl;
    logic            clk_prv_q, ld_prv_q;
    logic            clk_rise, clk_fall, ld_rise;
    logic            link_open;
    logic            shift_en, out_en;
    cmd_t            cmd_cur, cmd_next, frame_cmd, wr_cmd;
    logic            wr_en;
    rx_state_e       state_q;

    rx_sync #(
        .WIDTH  (IN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_load_i, ser_din_i, ser_clk_i}),
        .level_o (lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_prv_q <= 1'b0;
            ld_prv_q  <= 1'b0;
        end else begin
            clk_prv_q <= lvl[IN_CLK];
            ld_prv_q  <= lvl[IN_LD];
        end
    end

    assign clk_rise = lvl[IN_CLK] & ~clk_prv_q;
    assign clk_fall = ~lvl[IN_CLK] & clk_prv_q;
    assign ld_rise  = lvl[IN_LD] & ~ld_prv_q;

    // Interface variant: select-gated or free-running serial clock
    if (CS_MODE) begin : g_select
        assign link_open = ~ld_prv_q;
    end else begin : g_plain
        assign link_open = 1'b1;
    end

    assign shift_en = clk_rise & link_open;
    assign out_en   = clk_fall & link_open;

    rx_shifter u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en_i (shift_en),
        .out_en_i   (out_en),
        .din_i      (lvl[IN_DIN]),
        .cur_o      (cmd_cur),
        .next_o     (cmd_next),
        .dout_o     (ser_dout_o)
    );

    // A load edge coinciding with a clock edge takes the word including that bit
    assign frame_cmd = shift_en ? cmd_next : cmd_cur;

    rx_frame_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .shift_en_i  (shift_en),
        .load_rise_i (ld_rise),
        .frame_cmd_i (frame_cmd),
        .state_o     (state_q),
        .wr_en_o     (wr_en),
        .cmd_o       (wr_cmd)
    );

    rx_regfile #(
        .DIGITS (DIGITS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .cmd_i    (wr_cmd),
        .digits_o (digit_bus_o),
        .decode_o (decode_sel_o),
        .level_o  (level_o),
        .scan_o   (scan_lim_o),
        .power_o  (power_o),
        .test_o   (test_reg_o)
    );

    assign shutdown_o  = ~power_o[0];
    assign test_mode_o = test_reg_o[0];

endmodule

// File: rtl/disp_cmd_rx_chk.sv
module disp_cmd_rx_chk
    import disp_rx_pkg::*;
#(
    parameter int DIGITS  = 8,
    parameter bit CS_MODE = 1'b0
) (
    input logic                     clk,
    input logic                     rst_n,
    input rx_state_e                state_i,
    input logic                     wr_en_i,
    input cmd_t                     wr_cmd_i,
    input cmd_t                     cmd_cur_i,
    input logic                     ld_prv_i,
    input logic                     out_en_i,
    input logic                     dout_i,
    input logic [DIGITS*DATA_W-1:0] digits_i,
    input logic [DATA_W-1:0]        decode_i,
    input logic [DATA_W-1:0]        level_i,
    input logic [DATA_W-1:0]        scan_i,
    input logic [DATA_W-1:0]        power_i,
    input logic [DATA_W-1:0]        test_i,
    input logic                     shutdown_i
);

    // R2
    dout_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout_i) |-> $past(out_en_i));

    // R3
    regs_move_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({digits_i, decode_i, level_i, scan_i, power_i, test_i}) |-> $past(wr_en_i));

    // R4
    decode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_cmd_i.addr == A_DECODE) |=> (decode_i == $past(wr_cmd_i.data)));

    // R5
    dead_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_cmd_i.addr == A_NOP || wr_cmd_i.addr == 4'hD || wr_cmd_i.addr == 4'hE))
        |=> ($stable(digits_i) && $stable(decode_i) && $stable(level_i)
             && $stable(scan_i) && $stable(power_i) && $stable(test_i)));

    // R7
    power_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_cmd_i.addr == A_POWER) |=> (shutdown_i == !$past(wr_cmd_i.data[0])));

    // R8
    select_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (CS_MODE && ld_prv_i) |=> $stable(cmd_cur_i));

    // R3
    single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_COMMIT) |=> (state_i != ST_COMMIT));

endmodule

bind disp_cmd_rx disp_cmd_rx_chk #(
    .DIGITS  (DIGITS),
    .CS_MODE (CS_MODE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_i    (state_q),
    .wr_en_i    (wr_en),
    .wr_cmd_i   (wr_cmd),
    .cmd_cur_i  (cmd_cur),
    .ld_prv_i   (ld_prv_q),
    .out_en_i   (out_en),
    .dout_i     (ser_dout_o),
    .digits_i   (digit_bus_o),
    .decode_i   (decode_sel_o),
    .level_i    (level_o),
    .scan_i     (scan_lim_o),
    .power_i    (power_o),
    .test_i     (test_reg_o),
    .shutdown_i (shutdown_o)
);

// File: tb/disp_cmd_rx_tb.sv
module disp_cmd_rx_tb;

    localparam int HALF = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic sdin = 1'b0;
    logic sld = 1'b1;

    always #2 clk = ~clk;

    logic        o_dout [2];
    logic [63:0] o_dig  [2];
    logic [7:0]  o_dec  [2];
    logic [7:0]  o_lvl  [2];
    logic [7:0]  o_scan [2];
    logic [7:0]  o_pwr  [2];
    logic [7:0]  o_tst  [2];
    logic        o_sd   [2];
    logic        o_tm   [2];

    disp_cmd_rx #(.CS_MODE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_din_i(sdin), .ser_load_i(sld),
        .ser_dout_o(o_dout[0]), .digit_bus_o(o_dig[0]), .decode_sel_o(o_dec[0]),
        .level_o(o_lvl[0]), .scan_lim_o(o_scan[0]), .power_o(o_pwr[0]),
        .test_reg_o(o_tst[0]), .shutdown_o(o_sd[0]), .test_mode_o(o_tm[0])
    );

    disp_cmd_rx #(.CS_MODE(1'b1)) u_dut_cs (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_din_i(sdin), .ser_load_i(sld),
        .ser_dout_o(o_dout[1]), .digit_bus_o(o_dig[1]), .decode_sel_o(o_dec[1]),
        .level_o(o_lvl[1]), .scan_lim_o(o_scan[1]), .power_o(o_pwr[1]),
        .test_reg_o(o_tst[1]), .shutdown_o(o_sd[1]), .test_mode_o(o_tm[1])
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string req, input string what, input int inst,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s dev%0d actual=%h expected=%h", req, what, inst, act, exp);
        end
    endtask

    // Behavioural reference: input history, 16-bit queue, spill bit, address-indexed registers
    logic [3:0]  h_clk, h_din, h_ld;
    logic [15:0] m_sr   [2];
    logic        m_spill[2];
    logic        m_dout [2];
    logic        m_pend [2];
    logic [15:0] m_word [2];
    logic [7:0]  m_reg  [2][16];
    bit          gate;
    int          a;
    logic [63:0] dexp;

    always @(posedge clk) begin
        if (!rst_n) begin
            h_clk = '0; h_din = '0; h_ld = '0;
            for (int m = 0; m < 2; m++) begin
                m_sr[m] = '0; m_spill[m] = 1'b0; m_dout[m] = 1'b0;
                m_pend[m] = 1'b0; m_word[m] = '0;
                for (int r = 0; r < 16; r++) m_reg[m][r] = '0;
            end
        end else begin
            h_clk = {h_clk[2:0], sclk};
            h_din = {h_din[2:0], sdin};
            h_ld  = {h_ld[2:0], sld};
            for (int m = 0; m < 2; m++) begin
                gate = (m == 0) || !h_ld[3];
                if (m_pend[m]) begin
                    a = int'(m_word[m][11:8]);
                    if (a != 0 && a != 13 && a != 14) m_reg[m][a] = m_word[m][7:0];
                    m_pend[m] = 1'b0;
                end
                if (gate && h_clk[2] && !h_clk[3]) begin
                    m_spill[m] = m_sr[m][15];
                    m_sr[m] = {m_sr[m][14:0], h_din[2]};
                end
                if (gate && !h_clk[2] && h_clk[3]) m_dout[m] = m_spill[m];
                if (h_ld[2] && !h_ld[3]) begin
                    m_pend[m] = 1'b1;
                    m_word[m] = m_sr[m];
                end
            end
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            for (int m = 0; m < 2; m++) begin
                for (int d = 0; d < 8; d++) dexp[d*8 +: 8] = m_reg[m][d+1];
                chk("R2", "dout", m, 64'(o_dout[m]), 64'(m_dout[m]));
                chk("R4", "digits", m, o_dig[m], dexp);
                chk("R4", "decode", m, 64'(o_dec[m]), 64'(m_reg[m][9]));
                chk("R4", "level", m, 64'(o_lvl[m]), 64'(m_reg[m][10]));
                chk("R4", "scan", m, 64'(o_scan[m]), 64'(m_reg[m][11]));
                chk("R4", "power", m, 64'(o_pwr[m]), 64'(m_reg[m][12]));
                chk("R4", "test", m, 64'(o_tst[m]), 64'(m_reg[m][15]));
                chk("R7", "shutdown", m, 64'(o_sd[m]), 64'(!m_reg[m][12][0]));
                chk("R7", "testmode", m, 64'(o_tm[m]), 64'(m_reg[m][15][0]));
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_bit(input logic b);
        sdin = b;
        wait_n(HALF);
        sclk = 1'b1;
        wait_n(HALF);
        sclk = 1'b0;
    endtask

    // Sends n bits (MSB of the n-bit field first) in one load window
    task automatic send_bits(input logic [31:0] w, input int n, input bit early_ld);
        sld = 1'b0;
        wait_n(HALF);
        for (int i = n - 1; i >= 0; i--) begin
            sdin = w[i];
            wait_n(HALF);
            sclk = 1'b1;
            if (i == 0 && early_ld) sld = 1'b1;
            wait_n(HALF);
            sclk = 1'b0;
        end
        if (!early_ld) begin
            wait_n(1);
            sld = 1'b1;
        end
        wait_n(2 * HALF);
    endtask

    task automatic send_frame(input logic [15:0] w);
        send_bits({16'h0, w}, 16, 1'b0);
    endtask

    logic [63:0] snap_dig [2];
    logic [7:0]  snap_lvl [2];
    logic [15:0] tx_word;
    logic [63:0] dig_ref;

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        wait_n(8);

        // R6: reset state
        for (int m = 0; m < 2; m++) begin
            chk("R6", "shutdown after reset", m, 64'(o_sd[m]), 64'd1);
            chk("R6", "testmode after reset", m, 64'(o_tm[m]), 64'd0);
            chk("R6", "decode after reset", m, 64'(o_dec[m]), 64'd0);
            chk("R6", "level after reset", m, 64'(o_lvl[m]), 64'd0);
            chk("R6", "scan after reset", m, 64'(o_scan[m]), 64'd0);
            chk("R6", "digits after reset", m, o_dig[m], 64'd0);
            chk("R6", "dout after reset", m, 64'(o_dout[m]), 64'd0);
        end

        // R1: ignored top nibble carries junk
        send_frame(16'hA90F);
        for (int m = 0; m < 2; m++) chk("R1", "decode 0F", m, 64'(o_dec[m]), 64'h0F);

        // R4, R7: digit writes while still in shutdown
        dig_ref = '0;
        for (int d = 0; d < 8; d++) begin
            tx_word = {4'h0, 4'(d + 1), 8'(8'h13 * (d + 1))};
            send_frame(tx_word);
            dig_ref[d*8 +: 8] = 8'(8'h13 * (d + 1));
        end
        send_frame(16'h5A0B);
        send_frame(16'h0B05);
        for (int m = 0; m < 2; m++) begin
            chk("R4", "digit bus", m, o_dig[m], dig_ref);
            chk("R4", "level 0B", m, 64'(o_lvl[m]), 64'h0B);
            chk("R4", "scan 05", m, 64'(o_scan[m]), 64'h05);
            chk("R7", "still shutdown", m, 64'(o_sd[m]), 64'd1);
        end

        // R7: leave and re-enter shutdown, contents kept
        send_frame(16'h0C01);
        for (int m = 0; m < 2; m++) chk("R7", "normal op", m, 64'(o_sd[m]), 64'd0);
        send_frame(16'h0CFE);
        for (int m = 0; m < 2; m++) begin
            chk("R7", "shutdown bit0=0", m, 64'(o_sd[m]), 64'd1);
            chk("R7", "digits kept", m, o_dig[m], dig_ref);
            chk("R7", "level kept", m, 64'(o_lvl[m]), 64'h0B);
        end
        send_frame(16'h0F01);
        for (int m = 0; m < 2; m++) chk("R7", "test on", m, 64'(o_tm[m]), 64'd1);
        send_frame(16'h0F00);
        for (int m = 0; m < 2; m++) chk("R7", "test off", m, 64'(o_tm[m]), 64'd0);

        // R5: dead addresses
        for (int m = 0; m < 2; m++) snap_dig[m] = o_dig[m];
        send_frame(16'h00FF);
        send_frame(16'h0DFF);
        send_frame(16'hFEFF);
        for (int m = 0; m < 2; m++) begin
            chk("R5", "digits untouched", m, o_dig[m], snap_dig[m]);
            chk("R5", "level untouched", m, 64'(o_lvl[m]), 64'h0B);
            chk("R5", "decode untouched", m, 64'(o_dec[m]), 64'h0F);
            chk("R5", "power untouched", m, 64'(o_pwr[m]), 64'hFE);
        end

        // R3: load together with the 16th edge
        send_bits({16'h0, 16'h0A07}, 16, 1'b1);
        for (int m = 0; m < 2; m++) chk("R3", "early load level", m, 64'(o_lvl[m]), 64'h07);

        // R3: 17 bits, first one falls off
        send_bits({15'h0, 1'b1, 16'h0B03}, 17, 1'b0);
        for (int m = 0; m < 2; m++) chk("R3", "last 16 bits", m, 64'(o_scan[m]), 64'h03);

        // R8: clocks while load is high
        for (int i = 15; i >= 0; i--) pulse_bit(tx_word[0] ^ tx_word[0] ^ 16'h0A33 >> i);
        wait_n(HALF);
        sld = 1'b0;
        wait_n(HALF);
        sld = 1'b1;
        wait_n(2 * HALF);
        for (int m = 0; m < 2; m++) snap_lvl[m] = o_lvl[m];
        chk("R8", "plain mode shifts with load high", 0, 64'(snap_lvl[0]), 64'h33);
        chk("R8", "select mode ignores clocks", 1, 64'(snap_lvl[1]), 64'h07);

        // R2: 32-bit burst, second half reproduces the first at the output
        tx_word = 16'hC3A5;
        sld = 1'b0;
        wait_n(HALF);
        for (int i = 15; i >= 0; i--) pulse_bit(tx_word[i]);
        for (int i = 15; i >= 0; i--) begin
            pulse_bit(1'b0);
            wait_n(HALF);
            for (int m = 0; m < 2; m++)
                chk("R2", "delayed dout", m, 64'(o_dout[m]), 64'(tx_word[i]));
        end
        wait_n(1);
        sld = 1'b1;
        wait_n(2 * HALF);
        for (int m = 0; m < 2; m++) chk("R5", "chained no-op", m, o_dig[m], snap_dig[m]);

        wait_n(10);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule